// File: doc/BRIEF.md
# Indirect Auto-Increment Coefficient RAM Port

This block gives a host on a simple 32-bit register bus access to two coefficient memories that sit behind a small window of registers. Each memory has its own pair of registers: a control register and a data register. A write to the control register can load a start address and sets the transfer direction and whether the address steps on its own. After that, each access to the data register moves one word into or out of the memory. A whole per-channel block can be streamed by writing the control register once and then hitting the data register once per word.

One memory holds gain words (8 channels of 62 full-width words). The other holds shift amounts (8 channels of 14 words, 5 bits kept per word). The two ports share the bus and the clock but keep separate address counters and modes. In read direction the port keeps the word at the current address already fetched, so data reads complete with no wait states even when issued on consecutive cycles.

Top module: `coef_ram_bridge`

## Requirements
- R1: After reset both control registers read 0x00004000 (address 0, sequential stepping on, read direction) and `bus_rvalid` is low.
- R2: Byte offset 0x0 is the gain control register, 0x4 gain data, 0x8 shift control, 0xC shift data. A read returns its value on `bus_rdata` in the cycle after the request, with `bus_rvalid` high for that one cycle only. An access with byte-address bits [1:0] not zero changes nothing and a read of it returns 0.
- R3: Control register layout: address in bits [9:0], load-address in bit 12, sequential stepping in bit 14, direction in bit 15 (1 = write). A control write with bit 12 set loads the address; with bit 12 clear the address is kept and only bits 14 and 15 take effect. A control read returns the current address in [9:0], bit 14, bit 15 and zeros elsewhere (bit 12 reads 0).
- R4: In write direction a data write stores the word at the current address; with stepping on the address then advances by one.
- R5: In read direction a data read returns the word at the current address, zero-extended, then advances it when stepping is on; reads on consecutive cycles return consecutive words.
- R6: With stepping off, data accesses leave the address unchanged: repeated reads return the same word and repeated writes overwrite the same word.
- R7: A loaded address at or beyond the memory depth (496 gain, 112 shift) becomes 0; stepping from the last word wraps to 0.
- R8: A data write in read direction leaves memory and address unchanged; a data read in write direction returns 0 and leaves the address unchanged.
- R9: The shift memory keeps only bits [4:0] of each written word; reads return them with the upper bits zero.
- R10: Activity on one port never changes the other port's address, mode or memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by bus and memories |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW (4) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High in the cycle read data is valid |

## Verification
The hardest situation to reach is a direction or mode change that lands right after a write at the same address the prefetch is watching, followed at once by a read: a stale prefetched word would only show up there. The stimulus writes with stepping off, switches to read direction without a gap, and reads immediately, and it also runs 62 and 14 back-to-back reads with no idle cycles. Address wrap is reached by loading the last gain word and a start address beyond the shift depth, and misdirected data accesses are followed by control reads that expose the untouched address.

// File: rtl/coef_bridge_pkg.sv
package coef_bridge_pkg;
  localparam int ADDR_FIELD_W = 10;
  localparam int CTRL_LOAD_BIT = 12;
  localparam int CTRL_STEP_BIT = 14;
  localparam int CTRL_DIR_BIT = 15;
  localparam logic [31:0] CTRL_RESET_VAL = 32'h0000_4000;
  localparam int PORT_COUNT = 2;

  typedef struct packed {
    logic [ADDR_FIELD_W-1:0] addr;
    logic                    load;
    logic                    step;
    logic                    dir_wr;
  } ctrl_fields_t;
endpackage

// File: rtl/coef_ram.sv
module coef_ram #(
  parameter int DEPTH = 496,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // R7
  waddr_range_chk: assert property (@(posedge clk) we |-> (32'(waddr) < 32'(DEPTH)));
endmodule

// File: rtl/coef_port.sv
module coef_port
  import coef_bridge_pkg::*;
#(
  parameter int DEPTH = 496,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  ctrl_fields_t  ctrl_in,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [DW-1:0] data_in,
  output logic [31:0]   ctrl_rdata,
  output logic [31:0]   data_rdata
);
  logic [AW-1:0] addr_q, addr_nxt, addr_inc, load_addr;
  logic          step_q, dir_q;
  logic          wr_ok, rd_ok, advance, in_range;
  logic [DW-1:0] prefetch;

  assign wr_ok    = data_wr & dir_q;
  assign rd_ok    = data_rd & ~dir_q;
  assign advance  = (wr_ok | rd_ok) & step_q;
  assign in_range = 32'(ctrl_in.addr) < 32'(DEPTH);
  assign addr_inc = (32'(addr_q) == 32'(DEPTH - 1)) ? '0 : addr_q + 1'b1;

  always_comb begin
    load_addr = '0;
    if (in_range) load_addr = ctrl_in.addr[AW-1:0];
  end

  always_comb begin
    addr_nxt = addr_q;
    if (ctrl_wr && ctrl_in.load) addr_nxt = load_addr;
    else if (advance)            addr_nxt = addr_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      step_q <= CTRL_RESET_VAL[CTRL_STEP_BIT];
      dir_q  <= CTRL_RESET_VAL[CTRL_DIR_BIT];
    end else begin
      addr_q <= addr_nxt;
      if (ctrl_wr) begin
        step_q <= ctrl_in.step;
        dir_q  <= ctrl_in.dir_wr;
      end
    end
  end

  // The read port follows the next address so the current word is always waiting.
  coef_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (addr_q),
    .wdata (data_in),
    .raddr (addr_nxt),
    .rdata (prefetch)
  );

  always_comb begin
    ctrl_rdata = '0;
    ctrl_rdata[AW-1:0]        = addr_q;
    ctrl_rdata[CTRL_STEP_BIT] = step_q;
    ctrl_rdata[CTRL_DIR_BIT]  = dir_q;
  end

  assign data_rdata = dir_q ? 32'd0 : 32'(prefetch);

  // R7
  addr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(addr_q) < 32'(DEPTH));
  // R3
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_in.load && in_range) |=> (addr_q == $past(ctrl_in.addr[AW-1:0])));
  // R3
  mode_only_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !ctrl_in.load) |=> $stable(addr_q));
  // R6
  step_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((data_wr || data_rd) && !step_q) |=> $stable(addr_q));
  // R8
  wrong_dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((data_wr && !dir_q) || (data_rd && dir_q)) |=> $stable(addr_q));
  // R4
  write_step_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && dir_q && step_q && 32'(addr_q) != 32'(DEPTH - 1))
      |=> (32'(addr_q) == 32'($past(addr_q)) + 1));
endmodule

// File: rtl/coef_ram_bridge.sv
module coef_ram_bridge
  import coef_bridge_pkg::*;
#(
  parameter int CHANNELS    = 8,
  parameter int GAIN_WORDS  = 62,
  parameter int SHIFT_WORDS = 14,
  parameter int GAIN_W      = 32,
  parameter int SHIFT_W     = 5,
  parameter int BUS_AW      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);
  localparam int GAIN_DEPTH  = CHANNELS * GAIN_WORDS;
  localparam int SHIFT_DEPTH = CHANNELS * SHIFT_WORDS;

  logic         hit, is_data;
  logic         port_idx;
  ctrl_fields_t ctrl_in;
  logic [PORT_COUNT-1:0] ctrl_wr, data_wr, data_rd;
  logic [31:0]  ctrl_rd_v [PORT_COUNT];
  logic [31:0]  data_rd_v [PORT_COUNT];
  logic [31:0]  rd_word;

  assign hit      = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == '0);
  assign port_idx = bus_addr[3];
  assign is_data  = bus_addr[2];

  assign ctrl_in.addr   = bus_wdata[ADDR_FIELD_W-1:0];
  assign ctrl_in.load   = bus_wdata[CTRL_LOAD_BIT];
  assign ctrl_in.step   = bus_wdata[CTRL_STEP_BIT];
  assign ctrl_in.dir_wr = bus_wdata[CTRL_DIR_BIT];

  always_comb begin
    for (int p = 0; p < PORT_COUNT; p++) begin
      ctrl_wr[p] = bus_sel && hit && bus_we  && !is_data && (int'(port_idx) == p);
      data_wr[p] = bus_sel && hit && bus_we  &&  is_data && (int'(port_idx) == p);
      data_rd[p] = bus_sel && hit && !bus_we &&  is_data && (int'(port_idx) == p);
    end
  end

  for (genvar p = 0; p < PORT_COUNT; p++) begin : g_port
    localparam int DEP = (p == 0) ? GAIN_DEPTH : SHIFT_DEPTH;
    localparam int DW  = (p == 0) ? GAIN_W : SHIFT_W;
    coef_port #(.DEPTH(DEP), .DW(DW)) u_port (
      .clk        (clk),
      .rst        (rst),
      .ctrl_wr    (ctrl_wr[p]),
      .ctrl_in    (ctrl_in),
      .data_wr    (data_wr[p]),
      .data_rd    (data_rd[p]),
      .data_in    (bus_wdata[DW-1:0]),
      .ctrl_rdata (ctrl_rd_v[p]),
      .data_rdata (data_rd_v[p])
    );
  end

  always_comb begin
    rd_word = '0;
    if (hit) rd_word = is_data ? data_rd_v[port_idx] : ctrl_rd_v[port_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_sel && !bus_we;
      if (bus_sel && !bus_we) bus_rdata <= rd_word;
    end
  end

  // R2
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we) |=> bus_rvalid);
  // R2
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> !bus_rvalid);
  // R10
  one_port_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl_wr, data_wr, data_rd}));
endmodule

// File: tb/coef_ram_bridge_tb_top.sv
module coef_ram_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  logic [31:0] m_mem [2][496];
  int          m_addr [2];
  bit          m_step [2];
  bit          m_dir [2];
  int          dep [2] = '{496, 112};
  logic [31:0] dmask [2] = '{32'hFFFF_FFFF, 32'h0000_001F};

  always #10 clk = ~clk;

  coef_ram_bridge dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  // Monitor: compares each returned read against the scoreboard.
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL R2: unexpected rvalid, rdata=%h expected no read", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          miscompares++;
          $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic bus_op(input bit we, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  function automatic int step_addr(int p, int a);
    return (a + 1 == dep[p]) ? 0 : a + 1;
  endfunction

  task automatic ctrl_wr(int p, logic [31:0] v);
    bus_op(1'b1, p ? 4'h8 : 4'h0, v);
    if (v[12]) m_addr[p] = (int'(v[9:0]) < dep[p]) ? int'(v[9:0]) : 0;
    m_step[p] = v[14];
    m_dir[p]  = v[15];
  endtask

  task automatic data_wr(int p, logic [31:0] v);
    bus_op(1'b1, p ? 4'hC : 4'h4, v);
    if (m_dir[p]) begin
      m_mem[p][m_addr[p]] = v & dmask[p];
      if (m_step[p]) m_addr[p] = step_addr(p, m_addr[p]);
    end
  endtask

  task automatic data_rd(int p, string tag);
    exp_q.push_back(m_dir[p] ? 32'd0 : m_mem[p][m_addr[p]]);
    tag_q.push_back(tag);
    bus_op(1'b0, p ? 4'hC : 4'h4, 32'd0);
    if (!m_dir[p] && m_step[p]) m_addr[p] = step_addr(p, m_addr[p]);
  endtask

  task automatic ctrl_rd(int p, string tag);
    logic [31:0] e;
    e = 32'(m_addr[p]);
    e[14] = m_step[p];
    e[15] = m_dir[p];
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_op(1'b0, p ? 4'h8 : 4'h0, 32'd0);
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      m_addr[p] = 0; m_step[p] = 1'b1; m_dir[p] = 1'b0;
      for (int i = 0; i < 496; i++) m_mem[p][i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    vectors++;
    if (bus_rvalid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: rvalid=%b expected 0", bus_rvalid);
    end
    ctrl_rd(0, "R1");
    ctrl_rd(1, "R1");

    // R4: stream channel 1 of the gain memory
    ctrl_wr(0, 32'h0000_D03E);
    for (int i = 0; i < 62; i++) data_wr(0, 32'hA500_0000 ^ (i * 32'h0101_0101));
    ctrl_rd(0, "R4");
    // R5: read it back with no gaps
    ctrl_wr(0, 32'h0000_503E);
    for (int i = 0; i < 62; i++) data_rd(0, "R5");
    ctrl_rd(0, "R5");

    // R9: shift memory keeps 5 bits
    ctrl_wr(1, 32'h0000_D00E);
    for (int i = 0; i < 14; i++) data_wr(1, 32'hFFFF_FFE0 | 32'(i * 3));
    ctrl_wr(1, 32'h0000_500E);
    for (int i = 0; i < 14; i++) data_rd(1, "R9");
    // R10: gain port untouched by shift traffic
    ctrl_rd(0, "R10");

    // R3: load, then mode-only write, unused bits
    ctrl_wr(0, 32'h0000_5046);
    ctrl_wr(0, 32'h0000_83FF);
    ctrl_rd(0, "R3");
    ctrl_wr(0, 32'hFFFF_2C00);
    ctrl_rd(0, "R3");

    // R6: stepping off
    for (int i = 0; i < 3; i++) data_rd(0, "R6");
    ctrl_rd(0, "R6");
    ctrl_wr(0, 32'h0000_9046);
    data_wr(0, 32'd111);
    data_wr(0, 32'd222);
    ctrl_wr(0, 32'h0000_1046);
    data_rd(0, "R6");
    data_rd(0, "R6");

    // R7: wrap on load and on step
    ctrl_wr(1, 32'h0000_D258);
    ctrl_rd(1, "R7");
    ctrl_wr(0, 32'h0000_D1EF);
    data_wr(0, 32'h1111_1111);
    data_wr(0, 32'h2222_2222);
    ctrl_rd(0, "R7");
    ctrl_wr(0, 32'h0000_51EF);
    data_rd(0, "R7");
    data_rd(0, "R7");

    // R8: misdirected data accesses
    data_wr(0, 32'h0000_DEAD);
    ctrl_rd(0, "R8");
    ctrl_wr(0, 32'h0000_51EF);
    data_rd(0, "R8");
    ctrl_wr(0, 32'h0000_C000);
    data_rd(0, "R8");
    ctrl_rd(0, "R8");

    // R2: misaligned accesses do nothing
    bus_op(1'b1, 4'h2, 32'h0000_D005);
    exp_q.push_back(32'd0); tag_q.push_back("R2");
    bus_op(1'b0, 4'h1, 32'd0);
    ctrl_rd(0, "R2");
    ctrl_rd(1, "R10");

    idle();
    repeat (3) @(negedge clk);
    vectors++;
    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL R2: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule